// File: doc/BRIEF.md
# Binary Hit Pipeline and Frame Serializer

This block sits behind 128 discriminator outputs, one hit bit per channel, and keeps each crossing's hit word in a digital ring of columns clocked by the 40 MHz crossing clock. The columns are overwritten one after another. When a level-1 accept arrives, the block picks the column written a programmable number of crossings earlier. It queues that column, together with its column address, in a small store of pending events.

The serializer runs at half the clock rate. It drains the pending store one event at a time and emits a frame of constant length: a start pattern, an error flag, the column address and then every channel bit, with no zero suppression. All chips of this kind run in lockstep, so the column address and the fixed latency identify the crossing and no timestamp is carried. Data volume per trigger is fixed, whatever the occupancy.

Top module: `hit_readout`

## Requirements
- R1: After reset, column 0 is written first. On every clock edge the current `hitIn` word is written into the next column, and the write column wraps modulo the pipeline depth of 256.
- R2: A `trigger` sampled on clock edge k with `latency` = L (1 to 255) selects the hit word sampled on edge k−L. The frame for that trigger carries the column address (k−L) mod 256.
- R3: A frame is 139 bits, sent first to last in this order: two start bits, both 1; the error bit; the 8-bit column address, most significant bit first; then the channel bits from channel 0 up to channel 127.
- R4: Every frame is exactly 139 bits long, whether all channels are hit, none are, or any pattern between.
- R5: `bitStrobe` is high on every second clock cycle. `serOut` and `frameValid` change only on a clock edge on which `bitStrobe` was high, so each frame bit lasts two clock cycles.
- R6: `frameValid` is high for exactly the bits of a frame, and `serOut` is 0 whenever `frameValid` is low.
- R7: Up to 8 triggered events wait for readout. A trigger that arrives while 8 are waiting is discarded and produces no frame. This holds even if a frame starts on that same edge.
- R8: A discarded trigger sets the error bit of the next frame to start. Frames after that one carry an error bit of 0 unless another trigger is discarded.
- R9: Frames go out in trigger order, and frames held in the store are sent one after another with no other trigger needed.
- R10: While `rstN` is low, `frameValid` and `serOut` are 0, no events are pending and no error is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock, 40 MHz |
| rstN | input | 1 | Active-low synchronous reset |
| hitIn | input | 128 | One discriminator hit bit per channel |
| trigger | input | 1 | Level-1 accept strobe, one cycle per trigger |
| latency | input | 8 | Trigger latency in crossings (1 to 255) |
| serOut | output | 1 | Serial frame data at half the clock rate |
| frameValid | output | 1 | High while frame bits are on `serOut` |
| bitStrobe | output | 1 | Serial bit-rate enable; outputs advance on the edge where it is high |

## Verification
The hardest state to reach from the ports is a full pending store while a frame is on the wire, because the serializer starts draining one cycle after the first trigger. The bench sends a burst of twelve triggers on consecutive cycles. Nine are accepted and three are discarded. The bench then checks that exactly nine frames follow, with consecutive column addresses, and that only the second frame carries the error bit. A separate vector table sweeps latencies from 1 to 255, so the column address wraps, and uses empty, full, one-hot and hashed hit patterns.

// File: rtl/hit_readout_pkg.sv
package hit_readout_pkg;
  // strobes from the control path to the datapath, valid for one clock
  typedef struct packed {
    logic push;    // copy the selected pipeline column into the pending store
    logic load;    // move the oldest pending event into the frame shifter
    logic shift;   // advance the frame shifter by one bit
    logic errBit;  // error flag to place in the frame being loaded
  } ctlStrobes_t;
endpackage

// File: rtl/hro_ctl.sv
module hro_ctl
  import hit_readout_pkg::*;
#(
  parameter int PIPE_DEPTH = 256,
  parameter int FIFO_DEPTH = 8,
  parameter int FRAME_LEN  = 139,
  parameter int BIT_DIV    = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          trigger,
  input  logic [$clog2(PIPE_DEPTH)-1:0] latency,
  output ctlStrobes_t                   strb,
  output logic [$clog2(PIPE_DEPTH)-1:0] wrPtr,
  output logic [$clog2(PIPE_DEPTH)-1:0] rdCol,
  output logic [$clog2(FIFO_DEPTH)-1:0] fifoWr,
  output logic [$clog2(FIFO_DEPTH)-1:0] fifoRd,
  output logic                          busy,
  output logic                          serEn
);
  localparam int PTR_W = $clog2(PIPE_DEPTH);
  localparam int FAW   = $clog2(FIFO_DEPTH);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int BIT_W = $clog2(FRAME_LEN);
  localparam int DIV_W = $clog2(BIT_DIV);

  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] fifoCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             errPending;
  logic             full, empty, lastBit, finish;

  // bit-rate divider, BIT_DIV must be at least 2
  always_ff @(posedge clk) begin
    if (!rstN)                                divCnt <= '0;
    else if (divCnt == DIV_W'(BIT_DIV - 1))   divCnt <= '0;
    else                                      divCnt <= divCnt + 1'b1;
  end
  assign serEn = (divCnt == DIV_W'(BIT_DIV - 1));

  // pipeline write column; PIPE_DEPTH is a power of two, so subtraction wraps
  always_ff @(posedge clk) begin
    if (!rstN)                                 wrPtr <= '0;
    else if (wrPtr == PTR_W'(PIPE_DEPTH - 1))  wrPtr <= '0;
    else                                       wrPtr <= wrPtr + 1'b1;
  end
  assign rdCol = wrPtr - latency;

  assign full    = (fifoCnt == CNT_W'(FIFO_DEPTH));
  assign empty   = (fifoCnt == '0);
  assign lastBit = (bitCnt == BIT_W'(FRAME_LEN - 1));
  assign finish  = serEn && busy && lastBit;

  always_comb begin
    strb.push   = trigger && !full;
    strb.load   = serEn && !busy && !empty;
    strb.shift  = serEn && busy && !lastBit;
    strb.errBit = errPending;
  end

  // pending-event store pointers and occupancy
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoWr  <= '0;
      fifoRd  <= '0;
      fifoCnt <= '0;
    end else begin
      if (strb.push) fifoWr <= (fifoWr == FAW'(FIFO_DEPTH - 1)) ? '0 : fifoWr + 1'b1;
      if (strb.load) fifoRd <= (fifoRd == FAW'(FIFO_DEPTH - 1)) ? '0 : fifoRd + 1'b1;
      case ({strb.push, strb.load})
        2'b10:   fifoCnt <= fifoCnt + 1'b1;
        2'b01:   fifoCnt <= fifoCnt - 1'b1;
        default: fifoCnt <= fifoCnt;
      endcase
    end
  end

  // overflow flag: a new overflow wins over clearing by a load
  always_ff @(posedge clk) begin
    if (!rstN)                errPending <= 1'b0;
    else if (trigger && full) errPending <= 1'b1;
    else if (strb.load)       errPending <= 1'b0;
  end

  // frame sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      bitCnt <= '0;
    end else if (strb.load) begin
      busy   <= 1'b1;
      bitCnt <= '0;
    end else if (finish) begin
      busy   <= 1'b0;
    end else if (strb.shift) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  a_r7_fifo_bound: assert property (@(posedge clk) disable iff (!rstN)
    fifoCnt <= CNT_W'(FIFO_DEPTH));
  a_r7_drop_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (trigger && full && !strb.load) |=> (fifoCnt == CNT_W'(FIFO_DEPTH)));
  a_r8_err_set: assert property (@(posedge clk) disable iff (!rstN)
    (trigger && full) |=> errPending);
  a_r5_valid_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !serEn |=> $stable(busy));
  a_r4_frame_end: assert property (@(posedge clk) disable iff (!rstN)
    finish |=> !busy);
endmodule

// File: rtl/hro_dp.sv
module hro_dp
  import hit_readout_pkg::*;
#(
  parameter int NUM_CH     = 128,
  parameter int PIPE_DEPTH = 256,
  parameter int FIFO_DEPTH = 8,
  parameter int FRAME_LEN  = 139
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CH-1:0]             hitIn,
  input  ctlStrobes_t                   strb,
  input  logic [$clog2(PIPE_DEPTH)-1:0] wrPtr,
  input  logic [$clog2(PIPE_DEPTH)-1:0] rdCol,
  input  logic [$clog2(FIFO_DEPTH)-1:0] fifoWr,
  input  logic [$clog2(FIFO_DEPTH)-1:0] fifoRd,
  input  logic                          busy,
  output logic                          serOut
);
  localparam int PTR_W = $clog2(PIPE_DEPTH);

  logic [NUM_CH-1:0]    pipeMem [PIPE_DEPTH];
  logic [NUM_CH-1:0]    evtData [FIFO_DEPTH];
  logic [PTR_W-1:0]     evtAddr [FIFO_DEPTH];
  logic [NUM_CH-1:0]    evtRev;
  logic [FRAME_LEN-1:0] shiftReg;

  always_ff @(posedge clk) begin
    pipeMem[wrPtr] <= hitIn;
  end

  always_ff @(posedge clk) begin
    if (strb.push) begin
      evtData[fifoWr] <= pipeMem[rdCol];
      evtAddr[fifoWr] <= rdCol;
    end
  end

  // channel 0 leaves first, so it sits just below the header
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_rev
    assign evtRev[NUM_CH-1-ch] = evtData[fifoRd][ch];
  end

  always_ff @(posedge clk) begin
    if (!rstN)           shiftReg <= '0;
    else if (strb.load)  shiftReg <= {2'b11, strb.errBit, evtAddr[fifoRd], evtRev};
    else if (strb.shift) shiftReg <= {shiftReg[FRAME_LEN-2:0], 1'b0};
  end

  assign serOut = busy & shiftReg[FRAME_LEN-1];

  a_r3_start_bits: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (serOut && shiftReg[FRAME_LEN-2]));
  a_r6_no_shift_idle: assert property (@(posedge clk) disable iff (!rstN)
    strb.shift |-> busy);
endmodule

// File: rtl/hit_readout.sv
module hit_readout
  import hit_readout_pkg::*;
#(
  parameter int NUM_CH     = 128,
  parameter int PIPE_DEPTH = 256,
  parameter int FIFO_DEPTH = 8,
  parameter int BIT_DIV    = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CH-1:0]             hitIn,
  input  logic                          trigger,
  input  logic [$clog2(PIPE_DEPTH)-1:0] latency,
  output logic                          serOut,
  output logic                          frameValid,
  output logic                          bitStrobe
);
  localparam int PTR_W     = $clog2(PIPE_DEPTH);
  localparam int FAW       = $clog2(FIFO_DEPTH);
  localparam int FRAME_LEN = 3 + PTR_W + NUM_CH;

  ctlStrobes_t      strb;
  logic [PTR_W-1:0] wrPtr, rdCol;
  logic [FAW-1:0]   fifoWr, fifoRd;
  logic             busy, serEn;

  hro_ctl #(.PIPE_DEPTH(PIPE_DEPTH), .FIFO_DEPTH(FIFO_DEPTH),
            .FRAME_LEN(FRAME_LEN), .BIT_DIV(BIT_DIV)) u_ctl (
    .clk(clk), .rstN(rstN), .trigger(trigger), .latency(latency),
    .strb(strb), .wrPtr(wrPtr), .rdCol(rdCol), .fifoWr(fifoWr),
    .fifoRd(fifoRd), .busy(busy), .serEn(serEn));

  hro_dp #(.NUM_CH(NUM_CH), .PIPE_DEPTH(PIPE_DEPTH), .FIFO_DEPTH(FIFO_DEPTH),
           .FRAME_LEN(FRAME_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .hitIn(hitIn), .strb(strb), .wrPtr(wrPtr),
    .rdCol(rdCol), .fifoWr(fifoWr), .fifoRd(fifoRd), .busy(busy),
    .serOut(serOut));

  assign frameValid = busy;
  assign bitStrobe  = serEn;

  a_r6_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !frameValid |-> !serOut);
endmodule

// File: tb/hit_readout_test.sv
module hit_readout_test;
  localparam int NUM_CH    = 128;
  localparam int FRAME_LEN = 139;
  localparam int NVEC      = 5;
  // each vector: latency, hit pattern (0 none, 1 all, 2 one-hot, 3 hashed)
  localparam logic [15:0] VEC [NVEC] = '{
    {8'd1, 8'd3}, {8'd5, 8'd1}, {8'd100, 8'd0}, {8'd255, 8'd2}, {8'd37, 8'd3}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_CH-1:0] hitIn = '0;
  logic trigger = 1'b0;
  logic [7:0] latency = 8'd1;
  logic serOut, frameValid, bitStrobe;

  int nChecks = 0, nFail = 0, cyc = 0, patSel = 3;
  int frameCount = 0, bitIdx = 0, idleErr = 0, rateErr = 0;
  logic [NUM_CH-1:0] hist [256];
  logic [FRAME_LEN-1:0] rxFrame [32];
  int rxLen [32];
  logic [FRAME_LEN-1:0] curBits = '0;
  logic prevSer = 1'b0, prevFv = 1'b0, prevStrobe = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  hit_readout uut (.clk(clk), .rstN(rstN), .hitIn(hitIn), .trigger(trigger),
    .latency(latency), .serOut(serOut), .frameValid(frameValid), .bitStrobe(bitStrobe));

  function automatic logic [NUM_CH-1:0] hitWord(int c, int sel);
    logic [NUM_CH-1:0] w = '0;
    case (sel)
      1: w = '1;
      2: w[c % NUM_CH] = 1'b1;
      3: for (int i = 0; i < NUM_CH/32; i++)
           w[i*32 +: 32] = 32'((c + i) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
      default: w = '0;
    endcase
    return w;
  endfunction

  function automatic logic [FRAME_LEN-1:0] mkFrame(logic err, logic [7:0] addr,
                                                   logic [NUM_CH-1:0] d);
    logic [NUM_CH-1:0] rev;
    for (int i = 0; i < NUM_CH; i++) rev[NUM_CH-1-i] = d[i];
    return {2'b11, err, addr, rev};
  endfunction

  always @(posedge clk) cyc <= rstN ? cyc + 1 : 0;

  // stimulus: hit word for the coming edge, written to column cyc mod 256
  always @(negedge clk) begin
    hitIn <= hitWord(cyc, patSel);
    hist[cyc % 256] = hitWord(cyc, patSel);
  end

  // frame collector and timing monitor
  always @(negedge clk) begin
    if (rstN && cyc > 2) begin
      if ((serOut != prevSer || frameValid != prevFv) && !prevStrobe) rateErr++;
      if (bitStrobe == prevStrobe) rateErr++;
      if (!frameValid && serOut) idleErr++;
    end
    if (frameValid && bitStrobe) begin
      if (bitIdx < FRAME_LEN) curBits[FRAME_LEN-1-bitIdx] = serOut;
      bitIdx++;
    end
    if (prevFv && !frameValid) begin
      rxFrame[frameCount % 32] = curBits;
      rxLen[frameCount % 32] = bitIdx;
      frameCount++;
      bitIdx = 0;
      curBits = '0;
    end
    prevSer = serOut; prevFv = frameValid; prevStrobe = bitStrobe;
  end

  task automatic check(input bit ok, input string req,
                       input logic [255:0] act, input logic [255:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitFrames(int n);
    int guard = 0;
    while (frameCount < n && guard < 6000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic checkFrame(int idx, logic [FRAME_LEN-1:0] exp, string tag);
    logic [FRAME_LEN-1:0] got = rxFrame[idx % 32];
    check(got[FRAME_LEN-1 -: 2] == 2'b11, {tag, " R3 start bits"}, 256'(got[FRAME_LEN-1 -: 2]), 256'(2'b11));
    check(got[136] == exp[136], {tag, " R8 error bit"}, 256'(got[136]), 256'(exp[136]));
    check(got[135:128] == exp[135:128], {tag, " R2 column address"}, 256'(got[135:128]), 256'(exp[135:128]));
    check(got[127:0] == exp[127:0], {tag, " R1 R2 channel bits"}, 256'(got[127:0]), 256'(exp[127:0]));
    check(rxLen[idx % 32] == FRAME_LEN, {tag, " R4 frame length"}, 256'(rxLen[idx % 32]), 256'(FRAME_LEN));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int base, t, l;
    logic [FRAME_LEN-1:0] burstExp [12];
    repeat (4) @(negedge clk);
    check(frameValid == 1'b0, "R10 reset frameValid", 256'(frameValid), 256'(0));
    check(serOut == 1'b0, "R10 reset serOut", 256'(serOut), 256'(0));
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(frameValid == 1'b0, "R10 no frame after reset", 256'(frameValid), 256'(0));

    // table of latency / pattern vectors
    for (int v = 0; v < NVEC; v++) begin
      logic [FRAME_LEN-1:0] exp;
      latency = VEC[v][15:8];
      patSel  = int'(VEC[v][7:0]);
      repeat (300) @(negedge clk);
      t = cyc; l = int'(latency);
      exp = mkFrame(1'b0, 8'((t - l) % 256), hist[(t - l) % 256]);
      base = frameCount;
      trigger = 1'b1;
      @(negedge clk);
      trigger = 1'b0;
      waitFrames(base + 1);
      check(frameCount == base + 1, "R2 frame produced", 256'(frameCount), 256'(base + 1));
      checkFrame(base, exp, $sformatf("vec%0d", v));
    end

    // burst of twelve triggers: nine accepted, three dropped
    latency = 8'd10; patSel = 3;
    repeat (300) @(negedge clk);
    t = cyc; l = 10; base = frameCount;
    for (int j = 0; j < 12; j++) begin
      burstExp[j] = mkFrame(j == 1, 8'((t + j - l) % 256), hist[(t + j - l) % 256]);
      trigger = 1'b1;
      @(negedge clk);
    end
    trigger = 1'b0;
    waitFrames(base + 9);
    repeat (700) @(negedge clk);
    check(frameCount == base + 9, "R7 dropped triggers give no frame",
          256'(frameCount - base), 256'(9));
    for (int j = 0; j < 9; j++) checkFrame(base + j, burstExp[j], $sformatf("R9 burst%0d", j));

    check(idleErr == 0, "R6 serOut low while idle", 256'(idleErr), 256'(0));
    check(rateErr == 0, "R5 half-rate bit timing", 256'(rateErr), 256'(0));

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule